// File: doc/BRIEF.md
# Muxed clock with conditional pre-divider

This block derives one output clock from four slow source clocks. A two-bit select picks the source, and a two-stage divider chain divides it. The first stage is a pre-divider of 1 to 32. It sits only in the path of source 3; the other three sources skip it. The second stage is a post-divider of 1 to 4. The sources are sampled by a fast system clock, and all divider state runs in that clock domain. The block produces two outputs: a level output clock and a one-cycle enable that marks the start of each output period.

Software programs a 32-bit control word through a write port that has a per-bit write mask, so one field can be changed without disturbing the others. The value is read back on a plain read port. A new configuration does not act at once. The running divider holds it until its terminal count, which ends the current output period, and only then loads the whole configuration at once, source select included. This prevents runt pulses.

The divider is controlled by a three-state machine:
- ST_PASS is used for a total ratio of 1. The output follows the sampled source.
- ST_HIGH is the first part of a divided period.
- ST_LOW is the rest of the period.

It has these transitions:
- reload: at terminal count the machine goes to ST_PASS if the new ratio is 1, otherwise to ST_HIGH.
- half-way: ST_HIGH goes to ST_LOW when the phase reaches the half count.
- hold: ST_LOW stays in ST_LOW until the next terminal count.

Top module: `clk_mux_prediv`

## Requirements
- R1: The control word stores the source select at bits 17:16, the pre-divide field at bits 12:8 and the post-divide field at bits 5:4. A read returns those stored fields, and every other bit reads as zero.
- R2: A write changes only the bits whose write-mask bit is 1. All other stored bits keep their value.
- R3: After the active-low reset the control word reads zero. The block then uses source 0 with both ratios at 1, the output follows source 0, and the enable pulses once per source 0 period.
- R4: A select value s makes the output and enable derive from source s, for s in 0 to 3.
- R5: The pre-divide field is used only when the select is 3. For selects 0 to 2 it has no effect on the output period.
- R6: The output period, in source periods, is the total ratio N. N is (pre+1)*(post+1) for select 3 and (post+1) for other selects.
- R7: For N above 1, the output is high for floor(N/2) source periods and then low for the rest of the period. For N of 1, the output equals the sampled source level.
- R8: The enable is a single system-clock pulse at each terminal count, in the same cycle the output period restarts.
- R9: A new configuration, including the source select, takes effect only at the terminal count of the period that is running. Before that point the output keeps its old timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 4 | Four source clocks, slower than clk |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Per-bit write mask; 1 means the bit is written |
| rd_data | output | 32 | Stored control word |
| div_clk | output | 1 | Divided output clock |
| div_en | output | 1 | One-cycle pulse at each terminal count |

## Verification
The bench builds the block with its default parameters: a 5-bit pre-divide field, a 2-bit post-divide field and four sources. It runs the sources at half periods of 3, 4, 5 and 2 system cycles. With these values the bench can measure every one of the 128 pre/post pairs on source 3 within a modest cycle count. It also measures all four post ratios on the other sources, with the pre-divide field set to its maximum to show that it is bypassed. A behavioural phase-counter model predicts the output clock, the enable and the read-back on every cycle, including the stretch after a write where the old ratio must still run to its terminal count.

// File: rtl/clk_mux_prediv_pkg.sv
package clk_mux_prediv_pkg;

    localparam int REG_W    = 32;
    localparam int NUM_SRC  = 4;
    localparam int SEL_LSB  = 16;
    localparam int SEL_W    = 2;
    localparam int PRE_LSB  = 8;
    localparam int PRE_W    = 5;
    localparam int POST_LSB = 4;
    localparam int POST_W   = 2;
    localparam int PRE_SRC  = 3;
    localparam int N_W      = PRE_W + POST_W + 1;

    localparam logic [REG_W-1:0] SEL_MASK  = REG_W'((1 << SEL_W) - 1) << SEL_LSB;
    localparam logic [REG_W-1:0] PRE_MASK  = REG_W'((1 << PRE_W) - 1) << PRE_LSB;
    localparam logic [REG_W-1:0] POST_MASK = REG_W'((1 << POST_W) - 1) << POST_LSB;
    localparam logic [REG_W-1:0] FIELD_MASK = SEL_MASK | PRE_MASK | POST_MASK;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } phase_e;

endpackage

// File: rtl/clk_mux_prediv_ctrl.sv
module clk_mux_prediv_ctrl
    import clk_mux_prediv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] wr_mask,
    output logic [REG_W-1:0] rd_data,
    output cfg_t             cfg
);

    logic [REG_W-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ((ctrl_q & ~wr_mask) | (wr_data & wr_mask)) & FIELD_MASK;
        end
    end

    assign rd_data  = ctrl_q;
    assign cfg.sel  = ctrl_q[SEL_LSB +: SEL_W];
    assign cfg.pre  = ctrl_q[PRE_LSB +: PRE_W];
    assign cfg.post = ctrl_q[POST_LSB +: POST_W];

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~FIELD_MASK) == '0);  // R1

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((rd_data ^ $past(rd_data)) & ~$past(wr_mask)) == '0));  // R2

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));  // R2

endmodule

// File: rtl/clk_mux_prediv_edge.sv
module clk_mux_prediv_edge
    import clk_mux_prediv_pkg::*;
#(
    parameter int SRCS = NUM_SRC,
    parameter int SW   = SEL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SRCS-1:0] src_clk,
    input  logic [SW-1:0]   sel,
    output logic            lvl,
    output logic            rise
);

    logic [SRCS-1:0] samp_q;
    logic [SRCS-1:0] prev_q;

    for (genvar i = 0; i < SRCS; i++) begin : g_smp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                samp_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                samp_q[i] <= src_clk[i];
                prev_q[i] <= samp_q[i];
            end
        end
    end

    assign lvl  = samp_q[sel];
    assign rise = samp_q[sel] & ~prev_q[sel];

    AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && $stable(sel)) |=> !rise);  // R4

endmodule

// File: rtl/clk_mux_prediv_core.sv
module clk_mux_prediv_core
    import clk_mux_prediv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             lvl,
    input  cfg_t             cfg_next,
    output logic [SEL_W-1:0] act_sel,
    output logic             div_clk,
    output logic             div_en
);

    phase_e            state, state_n;
    cfg_t              act;
    logic [PRE_W-1:0]  pre_cnt;
    logic [POST_W-1:0] post_cnt;
    logic              en_q;

    logic [PRE_W-1:0]  pre_eff;
    logic [N_W-1:0]    p_lim, n_tot, n_half, phase, ph_next, n_new;
    logic              term;

    function automatic logic [N_W-1:0] ratio_of(cfg_t c);
        logic [PRE_W-1:0] pe;
        pe = (c.sel == SEL_W'(PRE_SRC)) ? c.pre : '0;
        return (N_W'(pe) + N_W'(1)) * (N_W'(c.post) + N_W'(1));
    endfunction

    assign pre_eff = (act.sel == SEL_W'(PRE_SRC)) ? act.pre : '0;
    assign p_lim   = N_W'(pre_eff) + N_W'(1);
    assign n_tot   = ratio_of(act);
    assign n_half  = n_tot >> 1;
    assign phase   = N_W'(post_cnt) * p_lim + N_W'(pre_cnt);
    assign ph_next = phase + N_W'(1);
    assign n_new   = ratio_of(cfg_next);
    assign term    = (pre_cnt == pre_eff) && (post_cnt == act.post);

    // next-state logic
    always_comb begin
        state_n = state;
        if (rise && term) begin
            state_n = (n_new == N_W'(1)) ? ST_PASS : ST_HIGH;
        end else if (rise) begin
            unique case (state)
                ST_PASS: state_n = ST_PASS;
                ST_HIGH: state_n = (ph_next == n_half) ? ST_LOW : ST_HIGH;
                ST_LOW:  state_n = ST_LOW;
                default: state_n = ST_PASS;
            endcase
        end
    end

    // state register with the counters and active configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_PASS;
            act      <= '0;
            pre_cnt  <= '0;
            post_cnt <= '0;
            en_q     <= 1'b0;
        end else begin
            state <= state_n;
            en_q  <= rise && term;
            if (rise) begin
                if (term) begin
                    act      <= cfg_next;
                    pre_cnt  <= '0;
                    post_cnt <= '0;
                end else if (pre_cnt == pre_eff) begin
                    pre_cnt  <= '0;
                    post_cnt <= post_cnt + 1'b1;
                end else begin
                    pre_cnt  <= pre_cnt + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        act_sel = act.sel;
        div_en  = en_q;
        unique case (state)
            ST_PASS: div_clk = lvl;
            ST_HIGH: div_clk = 1'b1;
            ST_LOW:  div_clk = 1'b0;
            default: div_clk = 1'b0;
        endcase
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && term) |=> $stable(act));  // R9

    AST_EN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        div_en |=> !div_en);  // R8

    AST_PASS_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS) |-> (n_tot == N_W'(1)));  // R7

    AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH) |-> (phase < n_half));  // R7

    AST_EN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        div_en |-> (phase == '0));  // R8

endmodule

// File: rtl/clk_mux_prediv.sv
module clk_mux_prediv
    import clk_mux_prediv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [REG_W-1:0]   wr_mask,
    output logic [REG_W-1:0]   rd_data,
    output logic               div_clk,
    output logic               div_en
);

    cfg_t             cfg_w;
    logic [SEL_W-1:0] act_sel;
    logic             lvl;
    logic             rise;

    clk_mux_prediv_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .rd_data (rd_data),
        .cfg     (cfg_w)
    );

    clk_mux_prediv_edge #(
        .SRCS (NUM_SRC),
        .SW   (SEL_W)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_clk (src_clk),
        .sel     (act_sel),
        .lvl     (lvl),
        .rise    (rise)
    );

    clk_mux_prediv_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .lvl      (lvl),
        .cfg_next (cfg_w),
        .act_sel  (act_sel),
        .div_clk  (div_clk),
        .div_en   (div_en)
    );

endmodule

// File: tb/test_clk_mux_prediv.sv
module test_clk_mux_prediv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_clk = 4'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] wr_mask = '0;
    logic [31:0] rd_data;
    logic        div_clk;
    logic        div_en;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit chk_on = 0;
    int cyc = 0;
    int half_p [4] = '{3, 4, 5, 2};
    int src_cnt [4] = '{0, 0, 0, 0};

    clk_mux_prediv i_clk_mux_prediv (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_clk (src_clk),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .rd_data (rd_data),
        .div_clk (div_clk),
        .div_en  (div_en)
    );

    always #5 clk = ~clk;

    // source clocks, each with its own half period in clk cycles
    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            src_cnt[i] = src_cnt[i] + 1;
            if (src_cnt[i] >= half_p[i]) begin
                src_cnt[i] = 0;
                src_clk[i] <= ~src_clk[i];
            end
        end
    end

    // behavioural reference model
    logic [31:0] m_reg;
    logic [3:0]  m_samp, m_prev;
    int          m_sel, m_n, m_ph;
    bit          m_hi, m_pass, m_en;

    function automatic int n_of(logic [31:0] r);
        int p;
        p = (r[17:16] == 2'd3) ? int'(r[12:8]) + 1 : 1;
        return p * (int'(r[5:4]) + 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = '0; m_samp = '0; m_prev = '0;
            m_sel = 0; m_n = 1; m_ph = 0;
            m_hi = 0; m_pass = 1; m_en = 0;
        end else begin
            m_en = 0;
            if (m_samp[m_sel] && !m_prev[m_sel]) begin
                if (m_ph == m_n - 1) begin
                    m_sel  = int'(m_reg[17:16]);
                    m_n    = n_of(m_reg);
                    m_ph   = 0;
                    m_pass = (m_n == 1);
                    m_hi   = !m_pass;
                    m_en   = 1;
                end else begin
                    m_ph = m_ph + 1;
                    if (!m_pass && m_ph == m_n / 2) m_hi = 0;
                end
            end
            m_prev = m_samp;
            m_samp = src_clk;
            if (wr_en) m_reg = ((m_reg & ~wr_mask) | (wr_data & wr_mask)) & 32'h0003_1F30;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on && !done) begin
            check(div_clk == (m_pass ? m_samp[m_sel] : m_hi), "R7 div_clk level", div_clk,
                  m_pass ? m_samp[m_sel] : m_hi);
            check(div_en == m_en, "R8 div_en pulse", div_en, m_en);
            check(rd_data == m_reg, "R1 read-back", rd_data, m_reg);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    task automatic wr(input logic [31:0] d, input logic [31:0] m);
        @(negedge clk);
        wr_en = 1; wr_data = d; wr_mask = m;
        @(negedge clk);
        wr_en = 0; wr_data = '0; wr_mask = '0;
    endtask

    task automatic wait_en();
        @(negedge clk);
        while (!div_en) @(negedge clk);
    endtask

    task automatic measure(input int sel, input int pre, input int post, input string req);
        int t;
        int n;
        wr({14'b0, 2'(sel), 3'b0, 5'(pre), 2'b0, 2'(post), 4'b0}, 32'hFFFF_FFFF);
        wait_en();
        wait_en();
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!div_en);
        n = (sel == 3) ? (pre + 1) * (post + 1) : (post + 1);
        check(t == n * 2 * half_p[sel], req, t, n * 2 * half_p[sel]);
    endtask

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        rst_n = 1;
        chk_on = 1;
        @(negedge clk);
        check(rd_data == 32'h0, "R3 reset read-back", rd_data, 0);
        check(div_en == 1'b0, "R3 reset enable low", div_en, 0);
        // R3: default ratio 1 on source 0
        wait_en();
        wait_en();
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!div_en);
        check(cnt == 6, "R3 default period", cnt, 6);

        // R1: unused bits read zero
        wr(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        @(negedge clk);
        check(rd_data == 32'h0003_1F30, "R1 field layout", rd_data, 32'h0003_1F30);
        // R2: masked writes change only selected bits
        wr(32'h0, 32'h0003_0000);
        @(negedge clk);
        check(rd_data == 32'h0000_1F30, "R2 mask select only", rd_data, 32'h0000_1F30);
        wr(32'hFFFF_FFFF, 32'h0000_0F00);
        @(negedge clk);
        check(rd_data == 32'h0000_1F30, "R2 mask keeps fields", rd_data, 32'h0000_1F30);
        wr(32'h0, 32'h0000_0030);
        @(negedge clk);
        check(rd_data == 32'h0000_1F00, "R2 mask post only", rd_data, 32'h0000_1F00);

        // R4 and R5: selects 0..2 with pre field at maximum (bypassed)
        for (int s = 0; s < 3; s++)
            for (int q = 0; q < 4; q++)
                measure(s, 31, q, "R5 pre bypass period");

        // R6: every pre/post pair on source 3
        for (int p = 0; p < 32; p++)
            for (int q = 0; q < 4; q++)
                measure(3, p, q, "R6 select 3 period");

        // R9: reload deferred to terminal count
        measure(3, 31, 3, "R6 longest period");
        wait_en();
        repeat (10) @(negedge clk);
        wr(32'h0, 32'hFFFF_FFFF);
        cnt = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (div_en) cnt++;
        end
        check(cnt == 0, "R9 old period still running", cnt, 0);
        wait_en();
        wait_en();
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!div_en);
        check(cnt == 6, "R9 new config after terminal", cnt, 6);

        // R4: source 1 and 2 with ratio 1
        measure(1, 0, 0, "R4 source 1 pass");
        measure(2, 0, 0, "R4 source 2 pass");

        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule